// File: doc/BRIEF.md
# Serial Peripheral Port Controller

This block is a byte-wide serial peripheral port for a processor bus. Software sets it up through a control register. It then either runs as bus master, generating the serial clock from a programmable divider of the system clock, or acts as a slave that follows an external clock while its select input is low. Every completed eight-bit exchange raises a completion flag. That flag can request an interrupt and is cleared by the interrupt acknowledge or by a fixed access sequence. A data write that arrives while a word is still moving is refused and reported as a write collision.

Each pad (serial clock, master-out data, master-in data, select) has a separate input, output and output-enable. The pad direction of the select line lives outside the block and is reported through `ss_drive`. If the block is a master, its select pad is an input and something pulls that pad low, the block assumes another master has taken the bus. It then falls back to slave mode, releases its clock and data outputs and raises the completion flag. In slave mode, raising the select line aborts the current word at once.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1) and the `irq` output are 0, and no pad output-enable is asserted.
- R2: While the enable bit (control bit 6) is 0, no output-enable is asserted and a data write (address 2) starts no transfer and leaves the completion flag at 0.
- R3: In master mode (control bit 4 set, bit 6 set), a data write while idle shifts the byte out on `mosi_o`. With the order bit (control bit 5) at 0 the most significant bit goes first; at 1 the least significant bit goes first. The byte received on `miso_i` is then read back from address 2.
- R4: The serial clock idles at the polarity bit (control bit 3). With the phase bit (control bit 2) at 0, data is sampled on the leading edge (the edge away from idle) and changed on the trailing edge. With the phase bit at 1, data changes on the leading edge and is sampled on the trailing edge.
- R5: A master transfer lasts 16*H system cycles, from the data-write edge to the edge that sets the completion flag. H is set by {status bit 0, control bits 1:0}: 000→2, 001→8, 010→32, 011→64, 100→1, 101→4, 110→16, 111→32.
- R6: The completion flag (status bit 7) sets when a word completes. `irq` is high while the flag and the interrupt enable (control bit 7) are both 1, and a one-cycle `irq_ack` pulse clears the flag.
- R7: A status read that sees the completion flag or the collision flag set, followed by any data-register access, clears both flags.
- R8: A data write during a transfer sets the collision flag (status bit 6) and leaves the byte being shifted out unchanged.
- R9: In master mode with `ss_drive` at 0, a low `ss_i` clears control bit 4, sets the completion flag and drops `sck_oe` and `mosi_oe` within four cycles.
- R10: In master mode with `ss_drive` at 1, a low `ss_i` has no effect: control bit 4 stays set and the transfer completes normally.
- R11: In slave mode, with `ss_i` low, the block captures eight bits from `mosi_i` on `sck_i` under the same polarity, phase and order rules. It drives the byte written beforehand on `miso_o`, and `miso_oe` is asserted only while `ss_i` is low.
- R12: In slave mode, raising `ss_i` in the middle of a word discards the partial word without setting the completion flag. The next eight bits then form a complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt taken; clears the completion flag |
| ss_drive | input | 1 | Select pad direction from the port logic, 1 = output |
| sck_i | input | 1 | Serial clock pad input |
| sck_o | output | 1 | Serial clock pad output |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data pad input |
| mosi_o | output | 1 | Master-out data pad output |
| mosi_oe | output | 1 | Master-out data output enable |
| miso_i | input | 1 | Master-in data pad input |
| miso_o | output | 1 | Master-in data pad output |
| miso_oe | output | 1 | Master-in data output enable |
| ss_i | input | 1 | Select pad input |
| ss_o | output | 1 | Select pad output (never driven by the block) |
| ss_oe | output | 1 | Select output enable (always 0) |

## Verification
Register changes appear on the bus in the cycle after the write or capture edge. The bench reads them one cycle after the triggering access, and for slave traffic it samples only after a settling delay. A master completion is due exactly 16*H cycles after the data-write edge, so the bench counts cycles from that edge until `irq` rises and compares the count with that figure. Slave pads pass through a two-stage synchronizer, so the block sees a pad change about three cycles late. The bench therefore holds each serial clock level for eight cycles and samples `miso_o` just before the next edge. It checks a mode fault four cycles after `ss_i` falls, one cycle more than the synchronizer and register need.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          irq_ack,
  input  logic          ss_drive,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_i,
  output logic          ss_o,
  output logic          ss_oe
);
  localparam int CNTW = $clog2(DW);
  localparam int HW   = $clog2(2 * DW);
  localparam logic [HW-1:0]   HLAST = HW'(2 * DW - 1);
  localparam logic [CNTW-1:0] CLAST = CNTW'(DW - 1);

  logic [DW-1:0]   ctrl;
  logic            spif, wcol, dbl, armed;
  logic [DW-1:0]   sr, rxb;
  logic            run, rbit, obit;
  logic [HW-1:0]   half;
  logic [5:0]      div, hlim;
  logic [CNTW-1:0] cnt;
  logic [1:0]      sck_s, mosi_s, ss_s;
  logic            sck_d;

  wire spie = ctrl[7];
  wire en   = ctrl[6];
  wire dord = ctrl[5];
  wire mstr = ctrl[4];
  wire cpol = ctrl[3];
  wire cpha = ctrl[2];

  wire is_m   = en & mstr;
  wire is_s   = en & ~mstr;
  wire ss_lo  = ~ss_s[1];
  wire s_act  = is_s & ss_lo;
  wire fault  = is_m & ~ss_drive & ss_lo;

  wire wr_ctl  = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire wr_st   = bus_sel & bus_wr & (bus_addr == 2'd1);
  wire wr_dat  = bus_sel & bus_wr & (bus_addr == 2'd2);
  wire rd_st   = bus_sel & ~bus_wr & (bus_addr == 2'd1);
  wire dat_acc = bus_sel & (bus_addr == 2'd2);
  wire clr     = dat_acc & armed;

  always_comb begin
    case ({dbl, ctrl[1:0]})
      3'b000:  hlim = 6'd1;
      3'b001:  hlim = 6'd7;
      3'b010:  hlim = 6'd31;
      3'b011:  hlim = 6'd63;
      3'b100:  hlim = 6'd0;
      3'b101:  hlim = 6'd3;
      3'b110:  hlim = 6'd15;
      default: hlim = 6'd31;
    endcase
  end

  wire tick   = run & (div == hlim);
  wire m_samp = tick & ~half[0];
  wire m_shft = tick & half[0];
  wire m_done = tick & (half == HLAST);

  wire lead    = (sck_s[1] != cpol) & (sck_d == cpol);
  wire trail   = (sck_s[1] == cpol) & (sck_d != cpol);
  wire s_samp  = s_act & (cpha ? trail : lead);
  wire s_setup = s_act & (cpha ? lead : trail);
  wire s_done  = s_samp & (cnt == CLAST);

  wire busy  = run | (s_act & (cnt != '0));
  wire start = wr_dat & is_m & ~busy & ~fault;

  wire          sr_top = dord ? sr[0] : sr[DW-1];
  wire [DW-1:0] sh_m   = dord ? {rbit, sr[DW-1:1]} : {sr[DW-2:0], rbit};
  wire [DW-1:0] sh_s   = dord ? {mosi_s[1], sr[DW-1:1]} : {sr[DW-2:0], mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= 2'b11;
      sck_d  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      ss_s   <= {ss_s[0], ss_i};
      sck_d  <= sck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      dbl  <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata;
      if (fault)  ctrl[4] <= 1'b0;
      if (wr_st)  dbl <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      half <= '0;
      div  <= '0;
      rbit <= 1'b0;
    end else begin
      if (!is_m || fault) begin
        run <= 1'b0;
      end else if (start) begin
        run  <= 1'b1;
        half <= '0;
        div  <= '0;
      end else if (run) begin
        if (tick) begin
          div  <= '0;
          half <= half + 1'b1;
          if (m_done) run <= 1'b0;
        end else begin
          div <= div + 1'b1;
        end
      end
      if (m_samp) rbit <= miso_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      rxb  <= '0;
      cnt  <= '0;
      obit <= 1'b0;
    end else begin
      if (start || (wr_dat && is_s && !busy)) sr <= bus_wdata;
      else if (m_shft)                        sr <= sh_m;
      else if (s_samp)                        sr <= sh_s;
      if (m_done) rxb <= sh_m;
      if (s_done) rxb <= sh_s;
      if (!s_act)      cnt <= '0;
      else if (s_samp) cnt <= s_done ? '0 : cnt + 1'b1;
      if ((s_samp && !cpha) || s_setup) obit <= sr_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (rd_st && (spif || wcol)) armed <= 1'b1;
      else if (dat_acc)            armed <= 1'b0;
      if (m_done || s_done || fault) spif <= 1'b1;
      else if (clr || irq_ack)       spif <= 1'b0;
      if (wr_dat && busy) wcol <= 1'b1;
      else if (clr)       wcol <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl;
      2'd1:    bus_rdata = {spif, wcol, {(DW-3){1'b0}}, dbl};
      2'd2:    bus_rdata = rxb;
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = spie & spif;
  assign sck_o   = run ? (cpol ^ half[0] ^ cpha) : cpol;
  assign sck_oe  = is_m;
  assign mosi_o  = sr_top;
  assign mosi_oe = is_m;
  assign miso_o  = s_act & ((!cpha && cnt == '0) ? sr_top : obit);
  assign miso_oe = s_act;
  assign ss_o    = 1'b1;
  assign ss_oe   = 1'b0;
endmodule

module spi_port_chk #(
  parameter int DW = 8,
  parameter int CNTW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DW-1:0]   ctrl,
  input logic            irq_ack,
  input logic            sck_o,
  input logic            sck_oe,
  input logic            mosi_oe,
  input logic            miso_oe,
  input logic            run,
  input logic            spif,
  input logic            wcol,
  input logic            fault,
  input logic            s_act,
  input logic            is_m,
  input logic            wr_dat,
  input logic            ss_lo,
  input logic [CNTW-1:0] cnt
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |-> (!sck_oe && !mosi_oe && !miso_oe));
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m && !run) |-> (sck_o == ctrl[3]));
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spif && irq_ack && !run && !s_act && !fault) |=> !spif);
  // R6
  xfer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && is_m) |-> spif);
  // R8
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && run) |=> wcol);
  // R9
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!ctrl[4] && spif));
  // R11
  miso_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!ctrl[4] && ss_lo));
  // R12
  slave_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_act |=> (cnt == '0));
endmodule

bind spi_port spi_port_chk #(.DW(DW), .CNTW(CNTW)) u_chk (.*);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  localparam int CLK_P = 10;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, irq_ack = 0, ss_drive = 0;
  logic sck_i = 0, sck_o, sck_oe;
  logic mosi_i = 0, mosi_o, mosi_oe;
  logic miso_i = 0, miso_o, miso_oe;
  logic ss_i = 1, ss_o, ss_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_port u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic get_rx(output logic [7:0] st, output logic [7:0] d);
    bus_read(2'd1, st);
    bus_read(2'd2, d);
  endtask

  function automatic logic [7:0] cfg(input bit ie, en, ord, ms, pol, pha, input logic [1:0] spr);
    return {ie, en, ord, ms, pol, pha, spr};
  endfunction

  task automatic m_xfer(input logic [7:0] tx, peer, input bit pol, pha, ord, output logic [7:0] got);
    got = 0;
    if (!pha) miso_i = peer[ord ? 0 : 7];
    bus_write(2'd2, tx);
    for (int i = 0; i < 8; i++) begin
      int k;
      k = ord ? i : 7 - i;
      if (pha) begin
        wait (sck_o != pol); #1 miso_i = peer[k];
        wait (sck_o == pol); #1 got[k] = mosi_o;
      end else begin
        wait (sck_o != pol); #1 got[k] = mosi_o;
        wait (sck_o == pol); #1;
        if (i < 7) miso_i = peer[ord ? i + 1 : 6 - i];
      end
    end
    clks(3);
  endtask

  task automatic s_xfer(input logic [7:0] pre, host, input bit pol, pha, ord, input int nb,
                        output logic [7:0] got);
    got = 0;
    sck_i = pol;
    bus_write(2'd2, pre);
    ss_i = 0;
    clks(4);
    for (int i = 0; i < nb; i++) begin
      int k;
      k = ord ? i : 7 - i;
      if (!pha) begin
        mosi_i = host[k]; clks(HP);
        got[k] = miso_o; sck_i = !pol; clks(HP);
        sck_i = pol; clks(HP);
      end else begin
        sck_i = !pol; mosi_i = host[k]; clks(HP);
        got[k] = miso_o; sck_i = pol; clks(HP);
      end
    end
    clks(4);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_read(2'd0, d); chk(d == 0, "R1 control reset", d, 0);
    bus_read(2'd1, d); chk(d == 0, "R1 status reset", d, 0);
    chk({irq, sck_oe, mosi_oe, miso_oe} == 0, "R1 outputs reset", {irq, sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    bit moved;
    moved = 0;
    bus_write(2'd0, cfg(1, 0, 0, 1, 0, 0, 2'b00));
    bus_write(2'd2, 8'hC3);
    for (int i = 0; i < 60; i++) begin
      clks(1);
      if (sck_o != 0 || sck_oe || mosi_oe || miso_oe) moved = 1;
    end
    chk(!moved, "R2 no pad activity when disabled", moved, 0);
    bus_read(2'd1, d); chk(d[7] == 0, "R2 no completion when disabled", d, 0);
    chk(irq == 0, "R2 no irq when disabled", irq, 0);
  endtask

  task automatic t_master(input bit pol, pha, ord, input logic [7:0] tx, peer);
    logic [7:0] got, st, d;
    bus_write(2'd0, cfg(0, 1, ord, 1, pol, pha, 2'b00));
    clks(2);
    chk(sck_o == pol && sck_oe, "R4 clock idles at polarity", sck_o, pol);
    m_xfer(tx, peer, pol, pha, ord, got);
    chk(got == tx, "R3 R4 mosi bits", got, tx);
    get_rx(st, d);
    chk(st[7], "R6 completion flag set", st, 8'h80);
    chk(d == peer, "R3 R4 received byte", d, peer);
  endtask

  task automatic t_rate(input logic [2:0] code, input int h);
    int n;
    logic [7:0] st, d;
    bus_write(2'd1, {7'b0, code[2]});
    bus_write(2'd0, cfg(1, 1, 0, 1, 0, 0, code[1:0]));
    bus_write(2'd2, 8'h55);
    n = 0;
    while (!irq && n < 5000) begin
      @(posedge clk); #1; n++;
    end
    chk(n == 16 * h, "R5 transfer length", n, 16 * h);
    chk(irq, "R6 irq raised", irq, 1);
    @(negedge clk); irq_ack = 1;
    @(posedge clk); #1 irq_ack = 0;
    chk(!irq, "R6 irq_ack clears flag", irq, 0);
    bus_read(2'd1, st); chk(st[7] == 0, "R6 flag cleared", st, 0);
    bus_read(2'd2, d);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_wcol;
    logic [7:0] got, st, d;
    bus_write(2'd0, cfg(0, 1, 0, 1, 0, 0, 2'b01));
    fork
      m_xfer(8'hA5, 8'h0F, 0, 0, 0, got);
      begin clks(40); bus_write(2'd2, 8'h3C); end
    join
    chk(got == 8'hA5, "R8 shift byte unchanged by collision", got, 8'hA5);
    bus_read(2'd1, st);
    chk(st[7:6] == 2'b11, "R8 collision flag set", st, 8'hC0);
    bus_read(2'd2, d);
    chk(d == 8'h0F, "R8 received byte intact", d, 8'h0F);
    bus_read(2'd1, st);
    chk(st[7:6] == 2'b00, "R7 sequence clears both flags", st, 0);
  endtask

  task automatic t_fault;
    logic [7:0] d;
    ss_drive = 0;
    bus_write(2'd0, cfg(0, 1, 0, 1, 0, 0, 2'b00));
    clks(2);
    chk(sck_oe && mosi_oe, "R9 master drives before fault", {sck_oe, mosi_oe}, 3);
    ss_i = 0;
    clks(4);
    chk(!sck_oe && !mosi_oe, "R9 outputs released", {sck_oe, mosi_oe}, 0);
    bus_read(2'd0, d); chk(d[4] == 0, "R9 master bit cleared", d, 8'h40);
    bus_read(2'd1, d); chk(d[7] == 1, "R9 completion flag on fault", d, 8'h80);
    ss_i = 1;
    bus_read(2'd2, d);
    bus_write(2'd0, 8'h00);
    clks(4);
  endtask

  task automatic t_ss_out;
    logic [7:0] got, st, d;
    ss_drive = 1;
    bus_write(2'd0, cfg(0, 1, 0, 1, 1, 0, 2'b00));
    ss_i = 0;
    m_xfer(8'h69, 8'hB2, 1, 0, 0, got);
    bus_read(2'd0, d); chk(d[4] == 1, "R10 master bit kept", d, 8'h58);
    chk(got == 8'h69, "R10 transfer unaffected", got, 8'h69);
    get_rx(st, d);
    chk(d == 8'hB2, "R10 received byte", d, 8'hB2);
    ss_i = 1; ss_drive = 0;
    clks(4);
  endtask

  task automatic t_slave(input bit pol, pha, ord, input logic [7:0] pre, host);
    logic [7:0] got, st, d;
    bus_write(2'd0, cfg(0, 1, ord, 0, pol, pha, 2'b00));
    sck_i = pol;
    clks(4);
    chk(!miso_oe, "R11 miso released while deselected", miso_oe, 0);
    s_xfer(pre, host, pol, pha, ord, 8, got);
    chk(miso_oe, "R11 miso driven while selected", miso_oe, 1);
    chk(got == pre, "R11 slave miso bits", got, pre);
    ss_i = 1;
    clks(4);
    chk(!miso_oe, "R11 miso released after deselect", miso_oe, 0);
    get_rx(st, d);
    chk(st[7], "R11 slave completion", st, 8'h80);
    chk(d == host, "R11 slave received byte", d, host);
  endtask

  task automatic t_abort;
    logic [7:0] got, st, d;
    bus_write(2'd0, cfg(0, 1, 0, 0, 0, 0, 2'b00));
    sck_i = 0;
    clks(4);
    s_xfer(8'h00, 8'hFF, 0, 0, 0, 3, got);
    ss_i = 1;
    clks(4);
    bus_read(2'd1, st);
    chk(st[7] == 0, "R12 partial word sets no flag", st, 0);
    s_xfer(8'h5A, 8'h96, 0, 0, 0, 8, got);
    ss_i = 1;
    clks(4);
    get_rx(st, d);
    chk(st[7], "R12 full word after abort completes", st, 8'h80);
    chk(d == 8'h96, "R12 word not mixed with partial", d, 8'h96);
  endtask

  initial begin
    clks(3);
    rst_n = 1;
    clks(2);
    t_reset();
    t_disabled();
    t_master(0, 0, 0, 8'hA3, 8'h5C);
    t_master(1, 1, 1, 8'h1E, 8'hD4);
    t_master(0, 1, 0, 8'h81, 8'h37);
    t_master(1, 0, 1, 8'h6C, 8'hE9);
    t_rate(3'b100, 1);
    t_rate(3'b000, 2);
    t_rate(3'b101, 4);
    t_rate(3'b011, 64);
    t_wcol();
    t_fault();
    t_ss_out();
    t_slave(0, 0, 0, 8'hC5, 8'h3A);
    t_slave(1, 1, 1, 8'h4B, 8'hE1);
    t_abort();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule